// File: doc/BRIEF.md
# Reloadable Zero-Interrupt Interval Timer

The block is a 16-bit down-counter driven through three byte-wide registers: two data registers that address the low and high byte of a reload value, and a control register holding enable, rate select, interrupt enable and a sticky zero flag. A prescaler divides the system clock by one of two parameterised ratios to make counter ticks. On each tick, a counter at zero reloads. Any other count decrements by one.

Each time the count moves from a nonzero value to zero, the block raises a sticky status flag when counting is enabled. It also raises a level interrupt when interrupts are enabled. Writing a data byte updates that half of the reload value and copies the whole reload value straight into the counter, so software can reposition the count at once. Reading the data registers returns the live count. The control register clears the flag and the interrupt, and writing it always restarts the prescaler interval.

Top module: `zero_interval_timer`

## Requirements
- R1: After reset the count reads 0xFFFF, the reload value is 0, the control register reads 0xE4 and `irq` is low.
- R2: A write to address 0 (low byte) or address 1 (high byte) replaces that byte of the reload value and loads the full reload value into the counter on the same edge. Reads of addresses 0 and 1 return the counter's low and high bytes.
- R3: While enabled, the counter ticks once every SLOW_DIV cycles when the rate bit (control bit 4) is 0, and once every FAST_DIV cycles when it is 1. The first tick comes exactly one interval after the edge that wrote the control register.
- R4: A tick with the count at zero reloads the reload value. A reload value of zero therefore keeps the count at zero.
- R5: A change of the count from nonzero to zero, by a tick or by a data write, sets the zero flag (control bit 1) when enable (bit 0) is 1. It raises `irq` when interrupt enable (bit 3) is 1. Zero to zero raises nothing.
- R6: A control write with bit 2 set clears the zero flag and `irq`, but only if the count is nonzero or enable was 0 before the write. Otherwise both stay as they were.
- R7: A control write with bit 3 at 0 drops `irq`.
- R8: With enable at 0 the counter holds its value.
- R9: The control register reads 0xE4 OR rate<<4 OR irq-enable<<3 OR zero-flag<<1 OR enable.
- R10: Address 3 reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 low data, 1 high data, 2 control, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt on zero |

## Verification
A wrong prescaler phase shows up as a count that moves one or more cycles early or late, so the bench compares the count on every cycle of its sweeps. A fault in the clear condition or the interrupt enable shows up in the control readback and on `irq` on the cycle after the control write. A fault in the reload or load path shows up on the first read after a data write, or on the first tick after the count reaches zero.

// File: rtl/zit_pkg.sv
// Shared register selects and control-field positions for the interval timer.
package zit_pkg;
    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int BIT_FAST = 4;
    localparam int BIT_IE   = 3;
    localparam int BIT_CLR  = 2;
    localparam int BIT_ZF   = 1;
    localparam int BIT_EN   = 0;
    localparam logic [7:0] CTL_ONES = 8'hE4;
endpackage

// File: rtl/zit_prescaler.sv
// Divides the clock into counter ticks at one of two rates.
// Assumes both ratios are at least 2; restart zeroes the phase.
module zit_prescaler #(
    parameter int SLOW_DIV = 2000,
    parameter int FAST_DIV = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    input  logic restart,
    output logic tick
);
    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PH_W    = $clog2(MAX_DIV);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] limit;

    // Last phase of the selected interval.
    assign limit = fast ? PH_W'(FAST_DIV - 1) : PH_W'(SLOW_DIV - 1);
    assign tick  = run && (phase_q == limit);

    // Phase counter: restart, advance while running, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (run)     phase_q <= tick ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/zit_counter.sv
// Reload register built from byte lanes, plus the down-counter.
// A byte write loads the counter at once and takes priority over a tick.
module zit_counter #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [BYTE_W-1:0]       wbyte,
    input  logic                    tick,
    output logic [LANES*BYTE_W-1:0] cnt,
    output logic                    zero_evt
);
    localparam int CNT_W = LANES * BYTE_W;

    logic [CNT_W-1:0] reload_q, reload_nx, cnt_q, cnt_nx;

    // One lane of the next reload value per data register.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign reload_nx[b*BYTE_W +: BYTE_W] =
            wr_lane[b] ? wbyte : reload_q[b*BYTE_W +: BYTE_W];
    end

    // Next count: load, reload at zero, decrement, or hold.
    always_comb begin
        if (|wr_lane)             cnt_nx = reload_nx;
        else if (!tick)           cnt_nx = cnt_q;
        else if (cnt_q == '0)     cnt_nx = reload_q;
        else                      cnt_nx = cnt_q - 1'b1;
    end

    assign zero_evt = (cnt_nx == '0) && (cnt_q != '0);
    assign cnt      = cnt_q;

    // State registers for the reload value and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '1;
        end else begin
            reload_q <= reload_nx;
            cnt_q    <= cnt_nx;
        end
    end
endmodule

// File: rtl/zit_ctrl.sv
// Control fields, sticky zero flag and interrupt line.
// A clear in the same cycle as a zero event wins over the event.
module zit_ctrl
    import zit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] wdata,
    input  logic       cnt_zero,
    input  logic       zero_evt,
    output logic       en,
    output logic       fast,
    output logic       ie,
    output logic       zflag,
    output logic       irq
);
    logic clr_ok;

    // The clear is refused while the count sits at zero with counting on.
    assign clr_ok = ctl_wr && wdata[BIT_CLR] && (!cnt_zero || !en);

    // Writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            fast <= 1'b0;
            ie   <= 1'b0;
        end else if (ctl_wr) begin
            en   <= wdata[BIT_EN];
            fast <= wdata[BIT_FAST];
            ie   <= wdata[BIT_IE];
        end
    end

    // Sticky zero flag.
    always_ff @(posedge clk) begin
        if (!rst_n)              zflag <= 1'b0;
        else if (clr_ok)         zflag <= 1'b0;
        else if (zero_evt && en) zflag <= 1'b1;
    end

    // Interrupt line: cleared by an accepted clear or by disabling it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                irq <= 1'b0;
        else if (clr_ok || (ctl_wr && !wdata[BIT_IE])) irq <= 1'b0;
        else if (zero_evt && ie)                   irq <= 1'b1;
    end
endmodule

// File: rtl/zero_interval_timer.sv
// Top of the interval timer: register decode, read mux and wiring.
// Assumes one register access per cycle; reads have no side effects.
module zero_interval_timer
    import zit_pkg::*;
#(
    parameter int SLOW_DIV = 2000,
    parameter int FAST_DIV = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int CNT_W  = BYTE_W * LANES;

    logic [LANES-1:0] wr_lane;
    logic             ctl_wr, tick, zero_evt;
    logic             en, fast, ie, zflag;
    logic [CNT_W-1:0] cnt_w;

    // Write decode.
    assign wr_lane = {wr_en && (addr == SEL_HI), wr_en && (addr == SEL_LO)};
    assign ctl_wr  = wr_en && (addr == SEL_CTL);

    zit_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(en), .fast(fast),
        .restart(ctl_wr), .tick(tick)
    );

    zit_counter #(.BYTE_W(BYTE_W), .LANES(LANES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_lane(wr_lane), .wbyte(wdata),
        .tick(tick), .cnt(cnt_w), .zero_evt(zero_evt)
    );

    zit_ctrl u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(wdata),
        .cnt_zero(cnt_w == '0), .zero_evt(zero_evt),
        .en(en), .fast(fast), .ie(ie), .zflag(zflag), .irq(irq)
    );

    // Read mux: live count bytes, control image, zero for the spare slot.
    always_comb begin
        unique case (addr)
            SEL_LO:  rdata = cnt_w[BYTE_W-1:0];
            SEL_HI:  rdata = cnt_w[CNT_W-1:BYTE_W];
            SEL_CTL: rdata = CTL_ONES | (8'(fast) << BIT_FAST) | (8'(ie) << BIT_IE)
                           | (8'(zflag) << BIT_ZF) | (8'(en) << BIT_EN);
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/zit_checker.sv
// Temporal checks on the interval timer, bound into every instance.
module zit_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [7:0]  wdata,
    input logic        irq,
    input logic        en,
    input logic        ie,
    input logic        zflag,
    input logic        tick,
    input logic [15:0] cnt
);
    a_r2_low_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> cnt[7:0] == $past(wdata));

    a_r2_high_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> cnt[15:8] == $past(wdata));

    a_r3_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(wr_en && addr[1] == 1'b0)) |=> $stable(cnt));

    a_r6_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2 && wdata[2] && cnt == 16'd0 && en && zflag) |=> zflag);

    a_r7_ie_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2 && !wdata[3]) |=> !irq);

    a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ie);
endmodule

bind zero_interval_timer zit_checker chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq(irq), .en(en), .ie(ie), .zflag(zflag), .tick(tick), .cnt(cnt_w)
);

// File: tb/zero_interval_timer_tb_top.sv
module zero_interval_timer_tb_top;
    localparam int SD = 10;
    localparam int FD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd3;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    zero_interval_timer #(.SLOW_DIV(SD), .FAST_DIV(FD)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic rd_cnt(output int v);
        logic [7:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic rd_ctl(output int v);
        logic [7:0] c;
        rd(2'd2, c);
        v = c;
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v, c;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_cnt(v);  chk("R1 count", v, 16'hFFFF);
        rd_ctl(c);  chk("R1 control", c, 8'hE4);
        chk("R1 irq", irq, 0);

        // R10 spare address
        wr(2'd3, 8'hFF);
        rd(2'd3, b); chk("R10 read", b, 0);
        rd_cnt(v);   chk("R10 count kept", v, 16'hFFFF);
        rd_ctl(c);   chk("R10 control kept", c, 8'hE4);

        // R2 byte loads
        wr(2'd0, 8'h05); rd_cnt(v); chk("R2 low load", v, 16'h0005);
        wr(2'd1, 8'h12); rd_cnt(v); chk("R2 high load", v, 16'h1205);
        wr(2'd1, 8'h00); rd_cnt(v); chk("R2 high clear", v, 16'h0005);
        rd_ctl(c); chk("R5 no flag on nonzero load", c, 8'hE4);

        // R3 R4 R5 slow sweep, reload 5, period of six ticks
        wr(2'd2, 8'h01);
        for (int n = 1; n <= 11 * SD; n++) begin
            @(negedge clk); #1;
            rd_cnt(v);
            chk("R3 R4 slow count", v, 5 - ((n / SD) % 6));
            rd_ctl(c);
            chk("R5 R9 flag", c, (n >= 5 * SD) ? 8'hE7 : 8'hE5);
            chk("R5 irq masked", irq, 0);
        end

        // R6 clear refused at zero while enabled (also when disabling)
        wr(2'd2, 8'h05); rd_ctl(c); chk("R6 refused", c, 8'hE7);
        wr(2'd2, 8'h04); rd_ctl(c); chk("R6 refused old enable", c, 8'hE6);
        wr(2'd2, 8'h04); rd_ctl(c); chk("R6 accepted disabled", c, 8'hE4);

        // R8 hold while disabled
        repeat (3 * SD) @(negedge clk);
        #1; rd_cnt(v); chk("R8 hold at zero", v, 0);

        // R3 R5 fast sweep with interrupt
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h19);
        for (int n = 1; n <= 2 * FD; n++) begin
            @(negedge clk); #1;
            rd_cnt(v);
            chk("R3 fast count", v, 2 - n / FD);
            chk("R5 irq", irq, (n >= 2 * FD) ? 1 : 0);
        end
        rd_ctl(c); chk("R9 fast image", c, 8'hFF);

        // R6 refused keeps irq, R7 ie off drops it
        wr(2'd2, 8'h1D); chk("R6 irq kept", irq, 1);
        wr(2'd2, 8'h11); chk("R7 irq dropped", irq, 0);
        rd_ctl(c); chk("R7 flag kept", c, 8'hF7);

        // R5 zero event from a data write
        wr(2'd2, 8'h08);
        wr(2'd2, 8'h0C); rd_ctl(c); chk("R6 clear when disabled", c, 8'hEC);
        wr(2'd0, 8'h07); chk("R5 no irq on nonzero", irq, 0);
        wr(2'd0, 8'h00); chk("R5 irq on load to zero", irq, 1);
        rd_ctl(c); chk("R5 no flag when disabled", c, 8'hEC);
        wr(2'd2, 8'h0C); chk("R6 irq cleared", irq, 0);
        wr(2'd0, 8'h00); chk("R5 zero to zero", irq, 0);

        // R4 reload of zero keeps zero, no event
        wr(2'd2, 8'h09);
        for (int n = 1; n <= 3 * SD; n++) begin
            @(negedge clk); #1;
            rd_cnt(v); chk("R4 zero reload", v, 0);
            chk("R4 no irq", irq, 0);
        end

        // R8 hold then R3 first tick after restart
        wr(2'd2, 8'h08);
        wr(2'd0, 8'h09);
        repeat (3 * SD) @(negedge clk);
        #1; rd_cnt(v); chk("R8 hold nonzero", v, 9);
        wr(2'd2, 8'h01);
        for (int n = 1; n <= SD; n++) begin
            @(negedge clk); #1;
            rd_cnt(v); chk("R3 first tick", v, (n == SD) ? 8 : 9);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule